// File: doc/BRIEF.md
# Serial Command Receiver with Double-Buffered Converter Code

This block takes 16-bit command words from a write-only three-wire serial port (active-low select, serial clock, serial data) and applies them to a double-buffered pair of 12-bit registers. One is a staging register. The other is the live register whose value drives the converter code output. The three port wires are brought into the system clock domain through synchronisers, and their edges are found there. No logic runs on the serial clock itself.

Each word carries a 4-bit opcode in its upper nibble and a 12-bit payload in its lower bits. The opcode selects one of four actions: stage the payload, copy the staged value to the live register, load both registers at once, or do nothing. A word takes effect when select is released, and only if exactly sixteen serial clock edges were counted while it was low. Every accepted word also produces a one-cycle strobe for a separate power controller. The strobe carries the opcode and the top two payload bits.

The serial clock high and low times must each last at least three system clock periods. Select and data must settle before the serial clock edge that follows them.

Top module: `sercmd_dbuf`

## Requirements
- R1: While `rst` is high, and after it is released, `dac_code` is 0 and the staging register is 0, so the output starts at zero scale. `pwr_stb` is low during reset.
- R2: While `ser_sel_n` is low, each rising edge of `ser_clk` shifts `ser_dat` into a 16-bit word, most significant bit first. Bits [15:12] of the word are the opcode and bits [11:0] are the payload.
- R3: A word executes only when `ser_sel_n` rises after exactly 16 counted rising edges. A frame with fewer or more edges changes no register and raises no strobe.
- R4: Opcode 4'b0001 writes the payload into the staging register and leaves `dac_code` unchanged.
- R5: Opcode 4'b1000 copies the staging register into the live register and ignores the payload.
- R6: Opcodes 4'b1001 and 4'b1111 write the payload into both the staging register and the live register.
- R7: Every other opcode leaves both registers unchanged. This covers 4'b0000, the reserved codes 4'b0010 to 4'b0111, 4'b1010 and 4'b1011, and the power codes 4'b1100, 4'b1101 and 4'b1110.
- R8: Each accepted word, whatever its opcode, raises `pwr_stb` for exactly one system clock. In that same cycle `pwr_op` shows the word's opcode and `pwr_sel` shows payload bits [11:10]. Both hold those values until the next accepted word.
- R9: With two synchroniser stages, the register update and the strobe appear at the third rising `clk` edge that samples `ser_sel_n` high after its rise.
- R10: The bit count restarts at every new selection. Serial clock edges seen while `ser_sel_n` is high are not counted, so a full word sent after a rejected short frame is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Serial select, active low, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| dac_code | output | 12 | Live converter code |
| pwr_stb | output | 1 | One-cycle pulse for each accepted word |
| pwr_op | output | 4 | Opcode of the last accepted word |
| pwr_sel | output | 2 | Payload bits [11:10] of the last accepted word |

## Verification
The bench targets the frame length boundary: 15-bit and 17-bit frames must be rejected. A design that only checks "at least 16" would execute the long frame, and one that fires on the sixteenth edge would act before select is released. A rejected short frame followed by idle clocking and then a full word catches a counter that is not cleared on deselect; such a design would reject the good word. The reserved and power opcodes are followed by a copy command, so a design that wrongly stages a payload reveals itself in `dac_code`. A cycle-exact reference model catches a strobe that lasts two cycles, a wrong bit order, and an extra or missing pipeline stage.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
    localparam int OP_W   = 4;
    localparam int DATA_W = 12;
    localparam int WORD_W = OP_W + DATA_W;
    localparam int CNT_W  = $clog2(WORD_W + 2);
    localparam int SEL_W  = 2;

    typedef logic [OP_W-1:0]   op_t;
    typedef logic [DATA_W-1:0] code_t;
    typedef logic [SEL_W-1:0]  sel_t;

    localparam op_t OP_STAGE  = 4'b0001;
    localparam op_t OP_COPY   = 4'b1000;
    localparam op_t OP_BOTH_A = 4'b1001;
    localparam op_t OP_BOTH_B = 4'b1111;

    typedef struct packed {
        op_t   op;
        code_t data;
    } word_t;

    typedef struct packed {
        logic wr_stage;
        logic wr_live;
        logic live_from_stage;
    } act_t;

    function automatic act_t decode_op(op_t op);
        act_t a;
        a = '0;
        unique case (op)
            OP_STAGE:             a.wr_stage = 1'b1;
            OP_COPY:              begin a.wr_live = 1'b1; a.live_from_stage = 1'b1; end
            OP_BOTH_A, OP_BOTH_B: begin a.wr_stage = 1'b1; a.wr_live = 1'b1; end
            default:              a = '0;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign lvl = stg[STAGES-1];
endmodule

// File: rtl/sercmd_frame.sv
module sercmd_frame
    import sercmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_n_lvl,
    input  logic             sclk_lvl,
    input  logic             dat_lvl,
    output word_t            word,
    output logic [CNT_W-1:0] cnt,
    output logic             go
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    logic prev_sclk, prev_sel_n;
    logic sclk_rise, sel_rise;
    logic [WORD_W-1:0] sh;

    assign sclk_rise = sclk_lvl & ~prev_sclk;
    assign sel_rise  = sel_n_lvl & ~prev_sel_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sclk  <= 1'b0;
            prev_sel_n <= 1'b1;
            sh         <= '0;
            cnt        <= '0;
        end else begin
            prev_sclk  <= sclk_lvl;
            prev_sel_n <= sel_n_lvl;
            if (sel_n_lvl) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                sh <= {sh[WORD_W-2:0], dat_lvl};
                if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
            end
        end
    end

    assign word = word_t'(sh);
    assign go   = sel_rise && (cnt == CNT_FULL);
endmodule

// File: rtl/sercmd_regs.sv
module sercmd_regs
    import sercmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  word_t word,
    output code_t stage_q,
    output code_t live_q,
    output logic  stb,
    output op_t   op_q,
    output sel_t  sel_q
);
    act_t act;
    assign act = decode_op(word.op);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            live_q  <= '0;
            stb     <= 1'b0;
            op_q    <= '0;
            sel_q   <= '0;
        end else begin
            stb <= go;
            if (go) begin
                op_q  <= word.op;
                sel_q <= word.data[DATA_W-1 -: SEL_W];
                if (act.wr_stage) stage_q <= word.data;
                if (act.wr_live)  live_q  <= act.live_from_stage ? stage_q : word.data;
            end
        end
    end
endmodule

// File: rtl/sercmd_dbuf.sv
module sercmd_dbuf
    import sercmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [DATA_W-1:0] dac_code,
    output logic              pwr_stb,
    output logic [OP_W-1:0]   pwr_op,
    output logic [SEL_W-1:0]  pwr_sel
);
    logic [2:0]       pins_lvl;
    word_t            word;
    logic [CNT_W-1:0] bit_cnt;
    logic             go;
    code_t            in_q;

    // bit order in the vector: [2] select, [1] data, [0] clock
    sercmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({ser_sel_n, ser_dat, ser_clk}),
        .lvl (pins_lvl)
    );

    sercmd_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .sel_n_lvl (pins_lvl[2]),
        .sclk_lvl  (pins_lvl[0]),
        .dat_lvl   (pins_lvl[1]),
        .word      (word),
        .cnt       (bit_cnt),
        .go        (go)
    );

    sercmd_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .word    (word),
        .stage_q (in_q),
        .live_q  (dac_code),
        .stb     (pwr_stb),
        .op_q    (pwr_op),
        .sel_q   (pwr_sel)
    );
endmodule

// File: rtl/sercmd_dbuf_chk.sv
module sercmd_dbuf_chk
    import sercmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] dac_code,
    input logic [DATA_W-1:0] in_q,
    input logic              pwr_stb,
    input logic [OP_W-1:0]   pwr_op,
    input logic [CNT_W-1:0]  cnt
);
    logic is_load_op;
    assign is_load_op = (pwr_op == 4'b0001) || (pwr_op == 4'b1000) ||
                        (pwr_op == 4'b1001) || (pwr_op == 4'b1111);

    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (dac_code == '0 && in_q == '0 && !pwr_stb));

    a_r3_exact_count: assert property (@(posedge clk) disable iff (rst)
        pwr_stb |-> $past(cnt) == CNT_W'(WORD_W));

    a_r4_stage_holds_live: assert property (@(posedge clk) disable iff (rst)
        (pwr_stb && pwr_op == 4'b0001) |-> $stable(dac_code));

    a_r5_copy_matches: assert property (@(posedge clk) disable iff (rst)
        (pwr_stb && pwr_op == 4'b1000) |-> (dac_code == in_q && $stable(in_q)));

    a_r6_both_match: assert property (@(posedge clk) disable iff (rst)
        (pwr_stb && (pwr_op == 4'b1001 || pwr_op == 4'b1111)) |-> dac_code == in_q);

    a_r7_other_ops_keep: assert property (@(posedge clk) disable iff (rst)
        (pwr_stb && !is_load_op) |-> ($stable(dac_code) && $stable(in_q)));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pwr_stb |=> !pwr_stb);

    a_r8_live_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !pwr_stb |-> ($stable(dac_code) && $stable(in_q)));
endmodule

bind sercmd_dbuf sercmd_dbuf_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dac_code (dac_code),
    .in_q     (in_q),
    .pwr_stb  (pwr_stb),
    .pwr_op   (pwr_op),
    .cnt      (bit_cnt)
);

// File: tb/sercmd_dbuf_test.sv
`timescale 1ns/1ps
module sercmd_dbuf_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_sel_n = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic [11:0] dac_code;
    logic        pwr_stb;
    logic [3:0]  pwr_op;
    logic [1:0]  pwr_sel;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rise_cyc = 0;
    int stb_cnt = 0;
    int last_lat = -1;
    bit done = 1'b0;

    sercmd_dbuf uut (
        .clk(clk), .rst(rst), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .dac_code(dac_code), .pwr_stb(pwr_stb), .pwr_op(pwr_op), .pwr_sel(pwr_sel)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model, three-cycle output delay
    int m_sh, m_cnt, m_in, m_dac, m_op, m_sel;
    bit m_stb, p_sel, p_sclk;
    int d_dac[3], d_op[3], d_sel[3];
    bit d_stb[3];

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_sh = 0; m_cnt = 0; m_in = 0; m_dac = 0; m_op = 0; m_sel = 0; m_stb = 0;
            p_sel = 1; p_sclk = 0;
            for (int i = 0; i < 3; i++) begin d_dac[i] = 0; d_op[i] = 0; d_sel[i] = 0; d_stb[i] = 0; end
        end else begin
            m_stb = 0;
            if (ser_sel_n && !p_sel && m_cnt == 16) begin
                m_stb = 1;
                m_op  = (m_sh >> 12) & 15;
                m_sel = (m_sh >> 10) & 3;
                case (m_op)
                    1:      m_in = m_sh & 12'hFFF;
                    8:      m_dac = m_in;
                    9, 15:  begin m_in = m_sh & 12'hFFF; m_dac = m_in; end
                    default: ;
                endcase
            end
            if (ser_sel_n) m_cnt = 0;
            else if (ser_clk && !p_sclk) begin
                m_sh = ((m_sh << 1) | ser_dat) & 16'hFFFF;
                if (m_cnt < 17) m_cnt++;
            end
            p_sel = ser_sel_n; p_sclk = ser_clk;
            d_dac[2] = d_dac[1]; d_dac[1] = d_dac[0]; d_dac[0] = m_dac;
            d_op[2]  = d_op[1];  d_op[1]  = d_op[0];  d_op[0]  = m_op;
            d_sel[2] = d_sel[1]; d_sel[1] = d_sel[0]; d_sel[0] = m_sel;
            d_stb[2] = d_stb[1]; d_stb[1] = d_stb[0]; d_stb[0] = m_stb;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R9 model dac_code", dac_code, d_dac[2]);
            chk("R8 model pwr_stb", pwr_stb, d_stb[2]);
            chk("R8 model pwr_op", pwr_op, d_op[2]);
            chk("R8 model pwr_sel", pwr_sel, d_sel[2]);
            if (pwr_stb) begin
                stb_cnt++;
                last_lat = cyc - rise_cyc;
            end
        end
    end

    task automatic send(input logic [15:0] w, input int nbits);
        @(negedge clk) ser_sel_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            ser_dat = (i < 16) ? w[15-i] : 1'b0;
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
        ser_sel_n = 1'b1;
        rise_cyc = cyc;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s0;
        repeat (5) @(negedge clk);
        chk("R1 dac_code in reset", dac_code, 0);
        chk("R1 pwr_stb in reset", pwr_stb, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 dac_code after reset", dac_code, 0);

        send(16'h1ABC, 16);
        chk("R4 stage leaves live", dac_code, 12'h000);
        send(16'h8FFF, 16);
        chk("R5 copy ignores payload", dac_code, 12'hABC);
        chk("R9 strobe latency", last_lat, 3);

        send(16'h9123, 16);
        chk("R2 msb first via load both", dac_code, 12'h123);
        send(16'hF456, 16);
        chk("R6 opcode 1111 live", dac_code, 12'h456);
        send(16'h8000, 16);
        chk("R6 opcode 1111 staged", dac_code, 12'h456);

        s0 = stb_cnt;
        send(16'h0777, 16); send(16'h2777, 16); send(16'h5777, 16); send(16'h7777, 16);
        send(16'hA777, 16); send(16'hB777, 16); send(16'hC777, 16); send(16'hE777, 16);
        chk("R7 live unchanged", dac_code, 12'h456);
        chk("R8 one strobe per word", stb_cnt - s0, 8);
        send(16'h8000, 16);
        chk("R7 staging unchanged", dac_code, 12'h456);

        send(16'hDC00, 16);
        chk("R8 op on strobe", pwr_op, 4'hD);
        chk("R8 sel on strobe", pwr_sel, 2'd3);

        s0 = stb_cnt;
        send(16'h9AAA, 15);
        chk("R3 short frame no change", dac_code, 12'h456);
        chk("R3 short frame no strobe", stb_cnt - s0, 0);
        send(16'h9BBB, 17);
        chk("R3 long frame no change", dac_code, 12'h456);
        chk("R3 long frame no strobe", stb_cnt - s0, 0);

        send(16'h9555, 15);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        send(16'h9321, 16);
        chk("R10 count restarts", dac_code, 12'h321);
        chk("R10 strobe after restart", stb_cnt - s0, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule